// File: doc/BRIEF.md
# Block-Granular Rotator with Stallable Pipeline

This block rotates a wide data word by a whole number of equal-width blocks. The word is `N_BLOCKS` blocks of `BLOCK_W` bits. A select input, `$clog2(N_BLOCKS)` bits wide, gives the rotation amount in blocks. Blocks that leave one end of the word come back in at the other end. The direction is fixed when the block is built: right by default, left when `ROT_LEFT` is set.

Words arrive on a receive stream and leave on a transmit stream. Both streams use a valid/ready handshake, and a word moves only on a clock edge where its valid and ready are both high. A metadata field of `META_W` bits (at least one bit is carried) travels with each word and comes out unchanged beside the rotated result. A typical use is to return the select value.

Latency is `IN_REG + STAGES + OUT_REG` cycles. `IN_REG` and `OUT_REG` each enable a register stage at one edge of the block. `STAGES` splits the logarithmic rotation network into segments separated by registers. With all three at zero the block is purely combinational.

Top module: `block_rotator`

## Requirements
- R1: With `ROT_LEFT`=0, output block j (bits j*BLOCK_W upward) equals input block (j+s) mod N_BLOCKS, where s is the select value accepted with that word. Select 0 is the identity.
- R2: With `ROT_LEFT`=1, output block j equals input block (j−s) mod N_BLOCKS.
- R3: The metadata presented with a word leaves the block unchanged, together with that same word.
- R4: With the transmit side always ready, a word accepted in cycle t is presented with `tx_valid` high in cycle t + IN_REG + STAGES + OUT_REG.
- R5: Words leave in the order they were accepted, with none lost and none duplicated. A transfer happens only on an edge where valid and ready are both high.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_meta` hold their values into the next cycle.
- R7: In a registered configuration, `rx_ready` is high when `tx_ready` is high or when fewer than IN_REG+STAGES+OUT_REG words are in flight. Otherwise it is low.
- R8: With all latencies zero, `tx_valid` follows `rx_valid`, `rx_ready` follows `tx_ready`, and the result appears in the same cycle.
- R9: A synchronous active-high `rst` clears every stage's valid flag. After reset `tx_valid` is low, and words in flight at the reset never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (unused when combinational) |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | N_BLOCKS*BLOCK_W | Word to rotate |
| rx_shift | input | $clog2(N_BLOCKS) | Rotation amount in blocks |
| rx_meta | input | max(META_W,1) | Side data carried with the word |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Block can accept a word |
| tx_data | output | N_BLOCKS*BLOCK_W | Rotated word |
| tx_meta | output | max(META_W,1) | Side data of the word on `tx_data` |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Downstream accepts the word |

## Verification
The assertions check four rules on every cycle. Each stage must capture every word it accepts. A stalled stage must hold its contents. `tx_ready` high must imply `rx_ready` high. Reset must empty the output. Only the bench's scenarios can show that the rotation and the metadata are correct for each select value, and that data stays in order with nothing lost through random stalls. The same holds for the exact latency in free flow, the exact point where backpressure fills the pipeline, and the discarding of in-flight words at reset. The bench sweeps every select value against several block patterns on a pipelined right-rotating instance. It checks a combinational left-rotating instance in parallel.

// File: rtl/block_rotator_pkg.sv
package block_rotator_pkg;
  function automatic int sel_width(input int blocks);
    return (blocks > 1) ? $clog2(blocks) : 1;
  endfunction

  function automatic int meta_width(input int w);
    return (w > 0) ? w : 1;
  endfunction
endpackage

// File: rtl/block_rotator_stage.sv
module block_rotator_stage #(
  parameter int PW = 8,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_pay,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_pay
);
  generate
    if (EN) begin : g_reg
      logic          vld_q;
      logic [PW-1:0] pay_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_pay   = pay_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
        end else if (in_valid && in_ready) begin
          vld_q <= 1'b1;
        end else if (out_ready) begin
          vld_q <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) pay_q <= in_pay;
      end

      // R5: an accepted word is present in the stage on the next cycle
      p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

      // R6: a stalled stage keeps its word
      p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
    end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_pay   = in_pay;
    end
  endgenerate
endmodule

// File: rtl/block_rotator_net.sv
module block_rotator_net #(
  parameter int N_BLOCKS = 8,
  parameter int BLOCK_W  = 8,
  parameter int SW       = 3,
  parameter int MW       = 1,
  parameter int STAGES   = 0,
  parameter bit ROT_LEFT = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [N_BLOCKS*BLOCK_W-1:0] in_data,
  input  logic [SW-1:0]               in_sel,
  input  logic [MW-1:0]               in_meta,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [N_BLOCKS*BLOCK_W-1:0] out_data,
  output logic [MW-1:0]               out_meta
);
  localparam int DW   = N_BLOCKS * BLOCK_W;
  localparam int PW   = DW + SW + MW;
  localparam int NSEG = STAGES + 1;

  function automatic logic [DW-1:0] rot_by(input logic [DW-1:0] x, input int k);
    logic [DW-1:0] y;
    int src;
    y = '0;
    for (int j = 0; j < N_BLOCKS; j++) begin
      src = ROT_LEFT ? ((j + N_BLOCKS - k) % N_BLOCKS) : ((j + k) % N_BLOCKS);
      y[j*BLOCK_W +: BLOCK_W] = x[src*BLOCK_W +: BLOCK_W];
    end
    return y;
  endfunction

  // applies the layers of the log network that belong to segment seg
  function automatic logic [DW-1:0] rot_seg(input logic [DW-1:0] d,
                                            input logic [SW-1:0] s, input int seg);
    logic [DW-1:0] r;
    r = d;
    for (int i = 0; i < SW; i++) begin
      if (((i * NSEG) / SW) == seg && s[i]) r = rot_by(r, 1 << i);
    end
    return r;
  endfunction

  logic [NSEG*PW-1:0] seg_pay;
  logic [NSEG-1:0]    seg_vld;
  logic [NSEG-1:0]    seg_rdy;

  assign seg_pay[PW-1:0] = {in_data, in_sel, in_meta};
  assign seg_vld[0]      = in_valid;
  assign in_ready        = seg_rdy[0];

  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [DW-1:0] cur_d;
      logic [SW-1:0] cur_s;
      logic [MW-1:0] cur_m;
      logic [DW-1:0] rot_d;

      assign {cur_d, cur_s, cur_m} = seg_pay[s*PW +: PW];
      assign rot_d = rot_seg(cur_d, cur_s, s);

      if (s < STAGES) begin : g_pipe
        block_rotator_stage #(.PW(PW), .EN(1'b1)) stage_i (
          .clk       (clk),
          .rst       (rst),
          .in_valid  (seg_vld[s]),
          .in_ready  (seg_rdy[s]),
          .in_pay    ({rot_d, cur_s, cur_m}),
          .out_valid (seg_vld[s+1]),
          .out_ready (seg_rdy[s+1]),
          .out_pay   (seg_pay[(s+1)*PW +: PW])
        );
      end else begin : g_last
        logic unused_sel;
        assign unused_sel = ^cur_s;
        assign out_data   = rot_d;
        assign out_meta   = cur_m;
        assign out_valid  = seg_vld[s];
        assign seg_rdy[s] = out_ready;
      end
    end
  endgenerate
endmodule

// File: rtl/block_rotator.sv
module block_rotator #(
  parameter int N_BLOCKS = 256,
  parameter int BLOCK_W  = 64,
  parameter int STAGES   = 0,
  parameter bit IN_REG   = 1'b0,
  parameter bit OUT_REG  = 1'b0,
  parameter bit ROT_LEFT = 1'b0,
  parameter int META_W   = 0,
  localparam int SW = block_rotator_pkg::sel_width(N_BLOCKS),
  localparam int MW = block_rotator_pkg::meta_width(META_W),
  localparam int DW = N_BLOCKS * BLOCK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rx_data,
  input  logic [SW-1:0] rx_shift,
  input  logic [MW-1:0] rx_meta,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic [MW-1:0] tx_meta,
  output logic          tx_valid,
  input  logic          tx_ready
);
  localparam int IPW = DW + SW + MW;
  localparam int OPW = DW + MW;
  localparam int TOTAL_LAT = int'(IN_REG) + STAGES + int'(OUT_REG);

  logic          a_valid, a_ready;
  logic [DW-1:0] a_data;
  logic [SW-1:0] a_sel;
  logic [MW-1:0] a_meta;
  logic          b_valid, b_ready;
  logic [DW-1:0] b_data;
  logic [MW-1:0] b_meta;

  block_rotator_stage #(.PW(IPW), .EN(IN_REG)) in_stage_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_valid),
    .in_ready  (rx_ready),
    .in_pay    ({rx_data, rx_shift, rx_meta}),
    .out_valid (a_valid),
    .out_ready (a_ready),
    .out_pay   ({a_data, a_sel, a_meta})
  );

  block_rotator_net #(
    .N_BLOCKS (N_BLOCKS),
    .BLOCK_W  (BLOCK_W),
    .SW       (SW),
    .MW       (MW),
    .STAGES   (STAGES),
    .ROT_LEFT (ROT_LEFT)
  ) net_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (a_valid),
    .in_ready  (a_ready),
    .in_data   (a_data),
    .in_sel    (a_sel),
    .in_meta   (a_meta),
    .out_valid (b_valid),
    .out_ready (b_ready),
    .out_data  (b_data),
    .out_meta  (b_meta)
  );

  block_rotator_stage #(.PW(OPW), .EN(OUT_REG)) out_stage_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (b_valid),
    .in_ready  (b_ready),
    .in_pay    ({b_data, b_meta}),
    .out_valid (tx_valid),
    .out_ready (tx_ready),
    .out_pay   ({tx_data, tx_meta})
  );

  // R7: a draining output never blocks the input
  p_ready_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> rx_ready);

  generate
    if (TOTAL_LAT > 0) begin : g_rst_chk
      // R9: reset empties the pipeline
      p_rst_clear_r9: assert property (@(posedge clk)
        rst |=> !tx_valid);
    end
  endgenerate
endmodule

// File: tb/block_rotator_tb_top.sv
module block_rotator_tb_top;
  localparam int NB = 8;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [DW-1:0] rx_data = '0;
  logic [2:0]    rx_shift = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [DW-1:0] tx_data;
  logic [2:0]    tx_meta;
  logic          tx_valid;
  logic          tx_ready = 1'b0;

  logic          c_rx_ready;
  logic [DW-1:0] c_tx_data;
  logic [2:0]    c_tx_meta;
  logic          c_tx_valid;
  logic          c_tx_ready = 1'b0;

  block_rotator #(.N_BLOCKS(NB), .BLOCK_W(BW), .STAGES(2), .IN_REG(1'b1),
    .OUT_REG(1'b1), .ROT_LEFT(1'b0), .META_W(3)) dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_shift(rx_shift),
    .rx_meta(rx_shift), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_meta(tx_meta), .tx_valid(tx_valid), .tx_ready(tx_ready));

  block_rotator #(.N_BLOCKS(NB), .BLOCK_W(BW), .STAGES(0), .IN_REG(1'b0),
    .OUT_REG(1'b0), .ROT_LEFT(1'b1), .META_W(3)) dut_c (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_shift(rx_shift),
    .rx_meta(~rx_shift), .rx_valid(rx_valid), .rx_ready(c_rx_ready),
    .tx_data(c_tx_data), .tx_meta(c_tx_meta), .tx_valid(c_tx_valid), .tx_ready(c_tx_ready));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  bit free_flow = 1'b0;
  logic [DW-1:0] q_d [0:4095];
  logic [2:0]    q_m [0:4095];
  int            q_t [0:4095];
  int wr = 0, rd = 0;
  bit held = 1'b0;
  logic [DW-1:0] held_d;
  logic [2:0]    held_m;
  logic [31:0]   lfsr = 32'h1d872b41;

  function automatic logic [DW-1:0] exp_rot(input logic [DW-1:0] x, input int s, input bit left);
    logic [DW-1:0] y;
    for (int j = 0; j < NB; j++)
      y[j*BW +: BW] = x[(left ? (j - s + NB) % NB : (j + s) % NB)*BW +: BW];
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, expv);
    end
  endtask

  task automatic step();
    #1;
    if (!rst) begin
      // R7: backpressure point
      chk(rx_ready == (tx_ready || (wr - rd) < LAT), "R7 rx_ready", 64'(rx_ready),
          64'(tx_ready || (wr - rd) < LAT));
      if (held) begin
        chk(tx_valid && tx_data == held_d && tx_meta == held_m, "R6 stall hold",
            tx_data, held_d);
      end
      if (tx_valid) begin
        if (rd == wr) chk(1'b0, "R5 unexpected word", tx_data, 64'd0);
        else begin
          chk(tx_data == q_d[rd], "R1 rotated data", tx_data, q_d[rd]);
          chk(tx_meta == q_m[rd], "R3 metadata", 64'(tx_meta), 64'(q_m[rd]));
          if (free_flow) chk(cyc - q_t[rd] == LAT, "R4 latency", 64'(cyc - q_t[rd]), 64'(LAT));
          if (tx_ready) rd++;
        end
      end
      held = tx_valid && !tx_ready;
      held_d = tx_data;
      held_m = tx_meta;
      if (rx_valid && rx_ready) begin
        q_d[wr] = exp_rot(rx_data, int'(rx_shift), 1'b0);
        q_m[wr] = rx_shift;
        q_t[wr] = cyc;
        wr++;
      end
      // R8 / R2: combinational left rotator
      chk(c_tx_valid == rx_valid && c_rx_ready == c_tx_ready, "R8 comb handshake",
          64'({c_tx_valid, c_rx_ready}), 64'({rx_valid, c_tx_ready}));
      chk(c_tx_data == exp_rot(rx_data, int'(rx_shift), 1'b1), "R2 left rotation",
          c_tx_data, exp_rot(rx_data, int'(rx_shift), 1'b1));
      chk(c_tx_meta == ~rx_shift, "R3 comb metadata", 64'(c_tx_meta), 64'(~rx_shift));
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic adv_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    @(negedge clk);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    // R9: reset state
    chk(tx_valid == 1'b0, "R9 reset tx_valid", 64'(tx_valid), 64'd0);
    chk(rx_ready == 1'b1, "R9 reset rx_ready", 64'(rx_ready), 64'd1);
    rst = 1'b0;

    // R1/R4: every select value against several patterns, free flow
    free_flow = 1'b1;
    tx_ready = 1'b1;
    for (int s = 0; s < NB; s++) begin
      for (int p = 0; p < 6; p++) begin
        for (int j = 0; j < NB; j++) rx_data[j*BW +: BW] = 8'(j * 17 + p * 53 + s + 1);
        if (p == 5) rx_data = {DW{1'b0}} | 64'hff;
        rx_shift = 3'(s);
        rx_valid = 1'b1;
        c_tx_ready = p[0];
        step();
      end
    end
    rx_valid = 1'b0;
    repeat (LAT + 2) step();
    free_flow = 1'b0;

    // R5/R6/R7: random valid and ready
    for (int k = 0; k < 600; k++) begin
      adv_lfsr();
      rx_valid = lfsr[3] | lfsr[9];
      tx_ready = lfsr[5] & (lfsr[12] | lfsr[17]);
      c_tx_ready = lfsr[7];
      rx_shift = lfsr[15:13];
      rx_data = {lfsr, ~lfsr ^ 32'(k)};
      step();
    end
    rx_valid = 1'b0;
    tx_ready = 1'b1;
    repeat (LAT + 4) step();
    chk(wr == rd, "R5 all words delivered", 64'(wr - rd), 64'd0);

    // R9: reset with words in flight
    tx_ready = 1'b0;
    rx_valid = 1'b1;
    rx_data = 64'h0123456789abcdef;
    repeat (LAT + 2) step();
    rx_valid = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    rd = wr;
    held = 1'b0;
    tx_ready = 1'b1;
    for (int k = 0; k < LAT + 2; k++) begin
      chk(tx_valid == 1'b0, "R9 flush after reset", 64'(tx_valid), 64'd0);
      step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule